// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block merges three independent reset requests into a single stretched system reset. The requests are an undervoltage flag from an external comparator, an active-low pushbutton line, and a timeout strobe from a watchdog. The undervoltage flag and the pushbutton line are asynchronous, so each passes through a two-flop synchronizer first. The pushbutton path also has a qualifier that rejects short low-going glitches and accepts only a low level held for a minimum number of cycles.

While any request is active, reset is held. Once the last request clears, reset stays asserted for a fixed release delay before it drops. Overlapping requests therefore merge into one longer pulse. Two outputs carry the reset, one active-high and one active-low, and they are always complements of each other. A two-bit code reports which source started the most recent reset. All timing is set in clock cycles by parameters.

Top module: `supv_reset_gen`

## Requirements
- R1: While `rst_n` is low, `sys_rst` is 1, `sys_rst_n` is 0 and `rst_cause` is 0 (power-on). After `rst_n` rises, reset stays asserted for exactly `TIMEOUT_CYC` cycles.
- R2: The undervoltage flag holds reset asserted. A flag that is high for L cycles produces a reset lasting L + `TIMEOUT_CYC` cycles. The flag reaches the output three clock edges after it changes, because the synchronizer adds two.
- R3: A low level on `btn_n_a` that lasts fewer than `DEB_CYC` consecutive cycles has no effect. `sys_rst` stays 0 and `rst_cause` keeps its previous value.
- R4: A low level on `btn_n_a` held for L ≥ `DEB_CYC` cycles produces a reset lasting L − `DEB_CYC` + 1 + `TIMEOUT_CYC` cycles.
- R5: Each cycle in which `wd_expire` is high counts as a request. A single-cycle strobe gives a reset of 1 + `TIMEOUT_CYC` cycles.
- R6: When requests overlap or follow each other within the release delay, reset runs without a break. It drops exactly `TIMEOUT_CYC` cycles after the last cycle in which any request was seen.
- R7: `sys_rst_n` is the logical complement of `sys_rst` in every cycle.
- R8: `rst_cause` is captured only when a reset begins from the released state, and it is held until the next such start. The codes are 0 = power-on, 1 = undervoltage, 2 = pushbutton, 3 = watchdog. When several requests begin together, the priority is undervoltage, then pushbutton, then watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low power-on reset of the block |
| uv_flag_a | input | 1 | Asynchronous undervoltage flag, active high |
| btn_n_a | input | 1 | Asynchronous pushbutton line, active low |
| wd_expire | input | 1 | Watchdog timeout strobe, synchronous to `clk` |
| sys_rst | output | 1 | Stretched reset, active high |
| sys_rst_n | output | 1 | Stretched reset, active low |
| rst_cause | output | 2 | Source code of the most recent reset |

## Verification
The bench builds the block with `TIMEOUT_CYC` = 20 and `DEB_CYC` = 5. With these values a complete reset pulse fits in a window of about a hundred cycles, so every pulse length can be counted exactly. Pushbutton pulses of 1, 4, 5 and 9 cycles fall on both sides of the qualification limit. One overlap case has a pushbutton request still active after the undervoltage flag has cleared. Another has a second request arriving while the release delay is still counting. Two aligned-arrival cases check the cause priority.

// File: rtl/supv_pkg.sv
package supv_pkg;

    typedef enum logic [1:0] {
        CAUSE_POR = 2'd0,
        CAUSE_UV  = 2'd1,
        CAUSE_BTN = 2'd2,
        CAUSE_WD  = 2'd3
    } cause_e;

endpackage

// File: rtl/supv_sync2.sv
module supv_sync2 #(
    parameter int               WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.s1 <= RST_VAL;
            st_q.s2 <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.s2;

endmodule

// File: rtl/supv_btn_qual.sv
module supv_btn_qual #(
    parameter int DEB_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_n_s,
    output logic pressed
);

    localparam int            CW   = $clog2(DEB_CYC + 1);
    localparam logic [CW-1:0] CMAX = CW'(DEB_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pressed;
    } qual_t;

    qual_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (btn_n_s) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != CMAX) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.pressed = !btn_n_s && (st_d.cnt == CMAX);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt     <= '0;
            st_q.pressed <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pressed = st_q.pressed;

endmodule

// File: rtl/supv_stretch.sv
module supv_stretch
    import supv_pkg::*;
#(
    parameter int TIMEOUT_CYC = 7000000
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req,
    input  cause_e src,
    output logic   active,
    output cause_e cause
);

    localparam int            TW   = $clog2(TIMEOUT_CYC + 1);
    localparam logic [TW-1:0] TMAX = TW'(TIMEOUT_CYC);

    typedef struct packed {
        logic [TW-1:0] tmr;
        logic          active;
        cause_e        cause;
    } stretch_t;

    stretch_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (req) begin
            st_d.tmr    = TMAX;
            st_d.active = 1'b1;
            if (!st_q.active) begin
                st_d.cause = src;
            end
        end else begin
            st_d.active = (st_q.tmr != '0);
            if (st_q.tmr != '0) begin
                st_d.tmr = st_q.tmr - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.tmr    <= TMAX;
            st_q.active <= 1'b1;
            st_q.cause  <= CAUSE_POR;
        end else begin
            st_q <= st_d;
        end
    end

    assign active = st_q.active;
    assign cause  = st_q.cause;

endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen
    import supv_pkg::*;
#(
    parameter int TIMEOUT_CYC = 7000000,
    parameter int DEB_CYC     = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       uv_flag_a,
    input  logic       btn_n_a,
    input  logic       wd_expire,
    output logic       sys_rst,
    output logic       sys_rst_n,
    output logic [1:0] rst_cause
);

    logic [1:0] sync_out;
    logic       uv_s;
    logic       btn_s;
    logic       btn_pressed;
    logic       req_any;
    cause_e     src_sel;
    logic       active;
    cause_e     cause;

    supv_sync2 #(
        .WIDTH   (2),
        .RST_VAL (2'b10)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({btn_n_a, uv_flag_a}),
        .q     (sync_out)
    );

    assign uv_s  = sync_out[0];
    assign btn_s = sync_out[1];

    supv_btn_qual #(
        .DEB_CYC (DEB_CYC)
    ) u_btn (
        .clk     (clk),
        .rst_n   (rst_n),
        .btn_n_s (btn_s),
        .pressed (btn_pressed)
    );

    always_comb begin
        req_any = uv_s || btn_pressed || wd_expire;
        if (uv_s) begin
            src_sel = CAUSE_UV;
        end else if (btn_pressed) begin
            src_sel = CAUSE_BTN;
        end else begin
            src_sel = CAUSE_WD;
        end
    end

    supv_stretch #(
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_stretch (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req_any),
        .src    (src_sel),
        .active (active),
        .cause  (cause)
    );

    assign sys_rst   = active;
    assign sys_rst_n = ~active;
    assign rst_cause = cause;

endmodule

// File: rtl/supv_reset_gen_chk.sv
module supv_reset_gen_chk #(
    parameter int TIMEOUT_CYC = 7000000,
    parameter int DEB_CYC     = 50
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wd_expire,
    input logic       uv_sync,
    input logic       btn_sync,
    input logic       btn_pressed,
    input logic       req_any,
    input logic       sys_rst,
    input logic [1:0] rst_cause
);

    localparam int            QW   = $clog2(TIMEOUT_CYC + 2);
    localparam logic [QW-1:0] QMAX = QW'(TIMEOUT_CYC + 1);
    localparam logic [QW-1:0] QLIM = QW'(TIMEOUT_CYC);
    localparam int            LW   = $clog2(DEB_CYC + 1);
    localparam logic [LW-1:0] LMAX = LW'(DEB_CYC);

    logic [QW-1:0] quiet_q;
    logic [LW-1:0] low_run_q;

    always_ff @(posedge clk) begin
        if (!rst_n || req_any) begin
            quiet_q <= '0;
        end else if (quiet_q != QMAX) begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || btn_sync) begin
            low_run_q <= '0;
        end else if (low_run_q != LMAX) begin
            low_run_q <= low_run_q + 1'b1;
        end
    end

    AST_HOLD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_q <= QLIM) |-> sys_rst); // R6

    AST_RELEASE_POINT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst) |-> (quiet_q == QMAX)); // R6

    AST_UV_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        uv_sync |=> sys_rst); // R2

    AST_WD_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        wd_expire |=> sys_rst); // R5

    AST_PRESS_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(btn_pressed) |-> (low_run_q == LMAX)); // R3

    AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst && $past(sys_rst)) |-> $stable(rst_cause)); // R8

endmodule

bind supv_reset_gen supv_reset_gen_chk #(
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .DEB_CYC     (DEB_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wd_expire   (wd_expire),
    .uv_sync     (uv_s),
    .btn_sync    (btn_s),
    .btn_pressed (btn_pressed),
    .req_any     (req_any),
    .sys_rst     (sys_rst),
    .rst_cause   (rst_cause)
);

// File: tb/test_supv_reset_gen.sv
module test_supv_reset_gen;

    localparam int T   = 20;
    localparam int DEB = 5;
    localparam int WIN = 130;

    // source: 0 undervoltage, 1 pushbutton, 2 watchdog
    localparam int NV = 8;
    localparam int VEC_SRC   [NV] = '{0, 1, 1, 2, 0, 1, 1, 2};
    localparam int VEC_LEN   [NV] = '{1, 4, 5, 1, 7, 1, 9, 3};
    localparam int VEC_DUR   [NV] = '{1 + T, 0, 5 - DEB + 1 + T, 1 + T,
                                      7 + T, 0, 9 - DEB + 1 + T, 3 + T};
    localparam int VEC_CAUSE [NV] = '{1, 1, 2, 3, 1, 1, 2, 3};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       uv_flag_a = 1'b0;
    logic       btn_n_a = 1'b1;
    logic       wd_expire = 1'b0;
    logic       sys_rst;
    logic       sys_rst_n;
    logic [1:0] rst_cause;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    supv_reset_gen #(
        .TIMEOUT_CYC (T),
        .DEB_CYC     (DEB)
    ) i_supv_reset_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .uv_flag_a (uv_flag_a),
        .btn_n_a   (btn_n_a),
        .wd_expire (wd_expire),
        .sys_rst   (sys_rst),
        .sys_rst_n (sys_rst_n),
        .rst_cause (rst_cause)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drives each source over its own span and counts cycles with reset high.
    task automatic run_window(input int uv_st, input int uv_len,
                              input int bt_st, input int bt_len,
                              input int wd_st, input int wd_len,
                              output int dur, output int mism);
        dur  = 0;
        mism = 0;
        for (int i = 0; i < WIN; i++) begin
            @(negedge clk);
            if (sys_rst) dur++;
            if (sys_rst_n == sys_rst) mism++;
            uv_flag_a = (i >= uv_st) && (i < uv_st + uv_len);
            btn_n_a   = !((i >= bt_st) && (i < bt_st + bt_len));
            wd_expire = (i >= wd_st) && (i < wd_st + wd_len);
        end
    endtask

    task automatic do_reset(input string tag);
        int dur;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk({tag, " R1 sys_rst in reset"}, int'(sys_rst), 1);
        chk({tag, " R1 sys_rst_n in reset"}, int'(sys_rst_n), 0);
        chk({tag, " R1 cause in reset"}, int'(rst_cause), 0);
        rst_n = 1'b1;
        dur = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (sys_rst) dur++;
        end
        chk({tag, " R1 hold after release"}, dur, T);
        chk({tag, " R1 cause after release"}, int'(rst_cause), 0);
    endtask

    initial begin
        int dur;
        int mism;
        do_reset("power-on");

        for (int k = 0; k < NV; k++) begin
            run_window(VEC_SRC[k] == 0 ? 2 : WIN, VEC_LEN[k],
                       VEC_SRC[k] == 1 ? 2 : WIN, VEC_LEN[k],
                       VEC_SRC[k] == 2 ? 2 : WIN, VEC_LEN[k],
                       dur, mism);
            // R2 undervoltage, R3/R4 pushbutton, R5 watchdog durations
            chk($sformatf("R2/R3/R4/R5 vector %0d duration", k), dur, VEC_DUR[k]);
            chk($sformatf("R8 vector %0d cause", k), int'(rst_cause), VEC_CAUSE[k]);
            chk($sformatf("R7 vector %0d complement mismatches", k), mism, 0);
        end

        // R6: pushbutton still held after undervoltage clears
        run_window(0, 30, 10, 40, WIN, 0, dur, mism);
        chk("R6 overlap uv+btn duration", dur, 51 + T);
        chk("R8 overlap uv+btn cause", int'(rst_cause), 1);

        // R6: new request during the release delay extends it
        run_window(10, 1, WIN, 0, 0, 1, dur, mism);
        chk("R6 extend during delay duration", dur, 13 + T);
        chk("R8 extend during delay cause", int'(rst_cause), 3);
        chk("R7 extend complement mismatches", mism, 0);

        // R8: undervoltage and watchdog requests arrive on the same edge
        run_window(0, 1, WIN, 0, 2, 1, dur, mism);
        chk("R8 uv over wd duration", dur, 1 + T);
        chk("R8 uv over wd cause", int'(rst_cause), 1);

        // R8: pushbutton and watchdog requests arrive on the same edge
        run_window(WIN, 0, 0, DEB, DEB + 2, 1, dur, mism);
        chk("R8 btn over wd duration", dur, 1 + T);
        chk("R8 btn over wd cause", int'(rst_cause), 2);

        // R3: a rejected glitch leaves the previous cause in place
        run_window(WIN, 0, 3, DEB - 1, WIN, 0, dur, mism);
        chk("R3 glitch no reset", dur, 0);
        chk("R3 glitch cause kept", int'(rst_cause), 2);

        do_reset("mid-run");

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule